// File: doc/BRIEF.md
# Four-Bit Lookahead Adder/Subtractor Slice

This block is a purely combinational 4-bit arithmetic slice. It adds or subtracts two unsigned 4-bit operands. Every carry comes straight from per-bit propagate and generate terms and the effective carry-in. No carry waits for the carry below it, so the delay through the slice does not grow with the bit position.

A mode input chooses the operation. When the mode is low, the slice adds the second operand and the external carry-in. When the mode is high, each bit of the second operand is inverted and the carry-in is forced to one, so the slice computes the two's-complement difference. Besides the top carry-out, the slice drives the carries into bits 1, 2 and 3, so that the surrounding logic can inspect them.

In the carry network, no AND or OR term has more than four inputs. The widest carry is regrouped to meet that limit and still gives the same logical value. The slice has no clock and no state. Its outputs follow its inputs.

Top module: `addsub_cla4`

## Requirements
- R1: With `sub_i` = 0, {`cout_o`, `sum_o`} equals `a_i` + `b_i` + `cin_i` as a 5-bit unsigned value.
- R2: With `sub_i` = 1, `sum_o` equals (`a_i` − `b_i`) modulo 16, computed as `a_i` + ~`b_i` + 1.
- R3: With `sub_i` = 1, `cin_i` has no effect on any output. `sum_o`, `cout_o` and `cmid_o` are the same for both values of `cin_i`.
- R4: With `sub_i` = 1, `cout_o` is 1 exactly when `a_i` ≥ `b_i` (unsigned, no borrow) and 0 when a borrow occurs.
- R5: `cmid_o[k-1]` for k = 1, 2, 3 is the carry into bit k. It equals bit k of the sum of the low k bits of `a_i`, the low k bits of the effective second operand, and the effective carry-in.
- R6: Each carry equals the generate term of the bit below it, ORed with that bit's propagate term ANDed with the carry into that bit. The top carry keeps this relation after the fan-in regrouping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand (inverted internally when subtracting) |
| cin_i | input | 1 | Carry-in, used only when adding |
| sub_i | input | 1 | Operation select: 0 add, 1 subtract |
| sum_o | output | 4 | Sum or difference |
| cmid_o | output | 3 | Carries into bits 1, 2, 3 (index 0 is into bit 1) |
| cout_o | output | 1 | Carry-out of bit 3 |

## Verification
The slice is driven with every pair of operands in both modes and with both carry-in values, 1024 patterns in all. The add passes with carry-in 0 and 1 show whether the external carry is injected at the bottom of the lookahead. The subtract passes with both carry-in values show whether the forced carry truly overrides the external pin. Patterns with equal operands, with `a_i` one below `b_i`, and with all-ones operands in both modes show whether the borrow sense of the carry-out is correct. They also show whether the regrouped top carry matches the full expansion when every propagate term is high.

// File: rtl/addsub_cla_pkg.sv
`timescale 1ns/1ps
package addsub_cla_pkg;
  // Slice width; the flattened carry network is written for this width.
  localparam int unsigned SLICE_W = 4;
  // Index width of a carry vector that includes the carry-in at bit 0.
  localparam int unsigned CVEC_W  = SLICE_W + 1;
  typedef logic [SLICE_W-1:0] nib_t;
  typedef logic [CVEC_W-1:0]  cvec_t;
endpackage

// File: rtl/operand_cond.sv
`timescale 1ns/1ps
module operand_cond
  import addsub_cla_pkg::*;
#(
  parameter int unsigned W = SLICE_W
) (
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] b_eff_o,
  output logic         cin_eff_o
);
  // Per-bit conditional inversion of the second operand.
  for (genvar i = 0; i < W; i++) begin : g_inv
    assign b_eff_o[i] = b_i[i] ^ sub_i;
  end

  // Subtract forces the +1 of the two's complement.
  assign cin_eff_o = cin_i | sub_i;

  always_comb begin
    if (!sub_i) begin
      AST_ADD_PASSES_B: assert (b_eff_o == b_i)
        else $error("operand changed in add mode"); // R1
    end
    if (sub_i) begin
      AST_SUB_FORCES_CIN: assert (cin_eff_o == 1'b1)
        else $error("carry-in not forced in subtract mode"); // R3
    end
  end
endmodule

// File: rtl/pg_gen.sv
`timescale 1ns/1ps
module pg_gen
  import addsub_cla_pkg::*;
#(
  parameter int unsigned W = SLICE_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o,
  output logic [W-1:0] g_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign p_o[i] = a_i[i] ^ b_i[i];
    assign g_o[i] = a_i[i] & b_i[i];
  end
endmodule

// File: rtl/cla_carry4.sv
`timescale 1ns/1ps
module cla_carry4
  import addsub_cla_pkg::*;
(
  input  nib_t  p_i,
  input  nib_t  g_i,
  input  logic  c0_i,
  output cvec_t c_o
);
  logic c1, c2, c3, c4;
  logic low_grp;  // carry out of bit 0, reused to bound the top term

  // Each carry is a two-level sum of products of P, G and c0 only.
  assign c1 = g_i[0] | (p_i[0] & c0_i);

  assign c2 = g_i[1]
            | (p_i[1] & g_i[0])
            | (p_i[1] & p_i[0] & c0_i);

  assign c3 = g_i[2]
            | (p_i[2] & g_i[1])
            | (p_i[2] & p_i[1] & g_i[0])
            | (p_i[2] & p_i[1] & p_i[0] & c0_i);

  // The full expansion would need a five-input AND and a five-input OR.
  // The two lowest terms are folded into one group first.
  assign low_grp = g_i[0] | (p_i[0] & c0_i);

  assign c4 = g_i[3]
            | (p_i[3] & g_i[2])
            | (p_i[3] & p_i[2] & g_i[1])
            | (p_i[3] & p_i[2] & p_i[1] & low_grp);

  assign c_o = {c4, c3, c2, c1, c0_i};

  always_comb begin
    for (int k = 0; k < SLICE_W; k++) begin
      AST_CARRY_RECURRENCE: assert (c_o[k+1] == (g_i[k] | (p_i[k] & c_o[k])))
        else $error("carry %0d breaks recurrence", k + 1); // R6
    end
  end
endmodule

// File: rtl/sum_gen.sv
`timescale 1ns/1ps
module sum_gen
  import addsub_cla_pkg::*;
#(
  parameter int unsigned W = SLICE_W
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] s_o
);
  for (genvar i = 0; i < W; i++) begin : g_sum
    assign s_o[i] = p_i[i] ^ c_i[i];
  end
endmodule

// File: rtl/addsub_cla4.sv
`timescale 1ns/1ps
module addsub_cla4
  import addsub_cla_pkg::*;
(
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       cin_i,
  input  logic       sub_i,
  output logic [3:0] sum_o,
  output logic [2:0] cmid_o,
  output logic       cout_o
);
  localparam int unsigned MID_W = SLICE_W - 1;

  nib_t  b_eff;
  logic  cin_eff;
  nib_t  prop;
  nib_t  gen;
  cvec_t carry;

  operand_cond #(.W(SLICE_W)) u_cond (
    .b_i       (b_i),
    .sub_i     (sub_i),
    .cin_i     (cin_i),
    .b_eff_o   (b_eff),
    .cin_eff_o (cin_eff)
  );

  pg_gen #(.W(SLICE_W)) u_pg (
    .a_i (a_i),
    .b_i (b_eff),
    .p_o (prop),
    .g_o (gen)
  );

  cla_carry4 u_carry (
    .p_i  (prop),
    .g_i  (gen),
    .c0_i (cin_eff),
    .c_o  (carry)
  );

  sum_gen #(.W(SLICE_W)) u_sum (
    .p_i (prop),
    .c_i (carry[SLICE_W-1:0]),
    .s_o (sum_o)
  );

  assign cmid_o = carry[MID_W:1];
  assign cout_o = carry[SLICE_W];

  always_comb begin
    if (!sub_i) begin
      AST_ADD_RESULT: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {4'b0, cin_i}))
        else $error("add result wrong"); // R1
    end
    if (sub_i) begin
      AST_SUB_RESULT: assert (sum_o == 4'(a_i - b_i))
        else $error("difference wrong"); // R2
      AST_NO_BORROW_FLAG: assert (cout_o == (a_i >= b_i))
        else $error("borrow sense wrong"); // R4
    end
  end
endmodule

// File: tb/addsub_cla4_tb.sv
`timescale 1ns/1ps
module addsub_cla4_tb;
  logic       clk;
  logic       rst;
  logic [3:0] a_i, b_i;
  logic       cin_i, sub_i;
  logic [3:0] sum_o;
  logic [2:0] cmid_o;
  logic       cout_o;

  int n_cmp;
  int n_bad;
  int cycles;
  bit done;

  addsub_cla4 u_dut (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sub_i  (sub_i),
    .sum_o  (sum_o),
    .cmid_o (cmid_o),
    .cout_o (cout_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d cin=%0d sub=%0d actual=%0d expected=%0d",
               req, a_i, b_i, cin_i, sub_i, act, exp);
    end
  endtask

  // Previous-pattern outputs, kept to compare the two carry-in passes.
  int sub_ref_sum [256];
  int sub_ref_cout[256];
  int sub_ref_mid [256];

  initial begin
    done = 1'b0;
    cycles = 0;
    fork
      begin
        while (!done) begin
          @(posedge clk);
          cycles++;
          if (cycles > 200000) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 200000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
          end
        end
      end
    join_none
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    rst = 1'b1;
    a_i = '0; b_i = '0; cin_i = 1'b0; sub_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // Quiet inputs during reset: 0 + 0 + 0.
    check("R1 reset sum", sum_o, 0);
    check("R1 reset cout", cout_o, 0);
    check("R5 reset carries", cmid_o, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int md = 0; md < 2; md++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int av = 0; av < 16; av++) begin
          for (int bv = 0; bv < 16; bv++) begin
            @(negedge clk);
            a_i = 4'(av); b_i = 4'(bv); cin_i = ci[0]; sub_i = md[0];
            @(posedge clk);
            #1;
            begin
              int beff, ceff, tot, mid;
              beff = (md == 1) ? (~bv & 15) : bv;
              ceff = (md == 1) ? 1 : ci;
              tot  = av + beff + ceff;
              mid  = 0;
              for (int k = 1; k < 4; k++) begin
                int msk;
                msk = (1 << k) - 1;
                mid |= (((av & msk) + (beff & msk) + ceff) >> k & 1) << (k - 1);
              end
              if (md == 0) begin
                check("R1 sum", sum_o, tot & 15);
                check("R1 cout", cout_o, tot >> 4);
              end else begin
                check("R2 difference", sum_o, (av - bv) & 15);
                check("R4 borrow", cout_o, (av >= bv) ? 1 : 0);
                if (ci == 0) begin
                  sub_ref_sum [av*16+bv] = sum_o;
                  sub_ref_cout[av*16+bv] = cout_o;
                  sub_ref_mid [av*16+bv] = cmid_o;
                end else begin
                  check("R3 cin ignored sum", sum_o, sub_ref_sum[av*16+bv]);
                  check("R3 cin ignored cout", cout_o, sub_ref_cout[av*16+bv]);
                  check("R3 cin ignored carries", cmid_o, sub_ref_mid[av*16+bv]);
                end
              end
              check("R5 R6 inner carries", cmid_o, mid);
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule